// File: doc/BRIEF.md
# Serial Byte Transmitter with Periodic Resynchronisation Gaps

This block sends bytes from a ready/valid input onto one asynchronous serial line. Each character has one low start bit, eight data bits with the least significant bit first, and one high stop bit. A configuration input can add a second stop bit.

A free-running counter sets every bit edge. It divides the clock by `CLKS_PER_BIT`, so the bit period is that many clock cycles, and a long stream shows no accumulated drift. A receiver that joins a continuous stream part way through can lock onto a data bit that it takes for a start bit. It can then stay out of step for as long as the stream has no pause. To prevent this, the block counts characters. After every `GAP_EVERY` characters it stops sending for `GAP_BITS` bit periods, which is longer than one character. During that pause the line is either held idle (high) or, when break mode is selected, driven low and then released high before the next start bit.

A new byte can be accepted while the final stop bit of the current frame is on the line. A stream that is offered without pause therefore runs with no idle time between characters, except at the inserted gaps.

Top module: `uart_resync_tx`

## Requirements
- R1: After reset the line is high, `tx_ready` is 1, `busy` is 0 and the character count is zero.
- R2: Each character is sent as a low start bit, eight data bits with bit 0 first, and then a high stop bit.
- R3: Every bit lasts exactly `CLKS_PER_BIT` clock cycles. The falling edge of the start bit and the start of the stop bit are exactly 9×`CLKS_PER_BIT` cycles apart. Characters offered without pause start exactly one frame length apart: 10 bits, or 11 bits with two stop bits.
- R4: In idle-gap mode, after every `GAP_EVERY`-th character the line stays high for `GAP_BITS` bit periods. The next start bit comes at least (frame + `GAP_BITS` + 1) bit periods after the previous start bit.
- R5: `break_mode` is sampled together with the character that ends a group. When it is 1, the gap is driven low for exactly `GAP_BITS` bit periods, starting right after the stop bit. The line is then high for at least one bit period before the next start bit.
- R6: `two_stop` is sampled with each byte. When it is 1, that character carries two high stop bits and its frame lasts 11 bit periods.
- R7: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both 1. `tx_ready` is 0 from that edge until the final stop bit begins, and for the whole of any gap. `busy` is 1 while a byte is waiting, a frame is on the line, or a gap is in progress.
- R8: Reset clears the character count, so the first gap after reset follows the `GAP_EVERY`-th character accepted after reset.
- R9: The line changes level only at bit boundaries set by the free-running bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_data | input | DATA_BITS | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Block can take a byte |
| two_stop | input | 1 | Send two stop bits (sampled with the byte) |
| break_mode | input | 1 | Drive the group gap low instead of high (sampled with the byte) |
| txd | output | 1 | Serial output line, registered |
| busy | output | 1 | A byte, frame or gap is in progress |

## Verification
The hardest case to reach from the ports is a byte arriving during the last stop bit of a character that closes a group. That byte has to wait through the whole gap, and in break mode it has to wait through the return to high as well. Only a back-to-back stream that is aligned to the group count shows whether the byte is held rather than started early. The bench therefore sends tight directed bursts of exactly one group and two groups in both gap modes and with two stop bits. It then sends a seeded random mix of bytes, modes and pauses. A decoder follows the line at mid-bit and checks the spacing of start bits to the exact cycle. It also checks the spacing across a reset that is applied part way through a group.

// File: rtl/uart_rtx_pkg.sv
package uart_rtx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_STOP  = 3'd3,
    ST_GAP   = 3'd4
  } tx_state_t;

  localparam int unsigned MIN_GAP_BITS = 11;

endpackage

// File: rtl/uart_rtx_baud.sv
module uart_rtx_baud #(
  parameter int unsigned CLKS_PER_BIT = 434
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int unsigned CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  // Free-running divider: bit edges are fixed instants, not elapsed delays.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (cnt_q == LAST) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = (cnt_q == LAST);

endmodule

// File: rtl/uart_rtx_groupcnt.sv
module uart_rtx_groupcnt #(
  parameter int unsigned GAP_EVERY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic char_end,
  output logic gap_next
);
  localparam int unsigned CW = (GAP_EVERY > 1) ? $clog2(GAP_EVERY) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP_EVERY - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (char_end) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // High while the character on the line is the last one of its group.
  assign gap_next = (cnt_q == LAST);

endmodule

// File: rtl/uart_rtx_frame.sv
module uart_rtx_frame
  import uart_rtx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 8,
  parameter int unsigned GAP_BITS  = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic [DATA_BITS-1:0] byte_i,
  input  logic                 valid_i,
  input  logic                 two_i,
  input  logic                 brk_i,
  input  logic                 gap_next_i,
  output logic                 ready_o,
  output logic                 busy_o,
  output logic                 txd_o,
  output logic                 char_end_o,
  output logic                 in_gap_o
);
  localparam int unsigned MAXC = (GAP_BITS > DATA_BITS) ? GAP_BITS : DATA_BITS;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam logic [CW-1:0] DATA_LAST = CW'(DATA_BITS - 1);
  localparam logic [CW-1:0] GAP_LAST  = CW'(GAP_BITS - 1);

  tx_state_t            state_q;
  logic [DATA_BITS-1:0] sh_q;
  logic [DATA_BITS-1:0] pend_byte_q;
  logic                 pend_q, pend_two_q, pend_brk_q;
  logic                 cur_two_q, cur_brk_q;
  logic                 stop2_q;
  logic [CW-1:0]        cnt_q;
  logic                 txd_q;

  logic                 last_stop;
  logic                 fire;
  logic                 have_next;
  logic [DATA_BITS-1:0] next_byte;
  logic                 next_two, next_brk;

  assign last_stop  = !cur_two_q || stop2_q;
  assign ready_o    = !pend_q &&
                      ((state_q == ST_IDLE) ||
                       (state_q == ST_STOP && last_stop && !gap_next_i));
  assign fire       = valid_i && ready_o;
  assign have_next  = pend_q || fire;
  assign next_byte  = pend_q ? pend_byte_q : byte_i;
  assign next_two   = pend_q ? pend_two_q  : two_i;
  assign next_brk   = pend_q ? pend_brk_q  : brk_i;
  assign char_end_o = tick && (state_q == ST_STOP) && last_stop;
  assign in_gap_o   = (state_q == ST_GAP);
  assign busy_o     = pend_q || (state_q != ST_IDLE);
  assign txd_o      = txd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      sh_q        <= '0;
      pend_byte_q <= '0;
      pend_q      <= 1'b0;
      pend_two_q  <= 1'b0;
      pend_brk_q  <= 1'b0;
      cur_two_q   <= 1'b0;
      cur_brk_q   <= 1'b0;
      stop2_q     <= 1'b0;
      cnt_q       <= '0;
      txd_q       <= 1'b1;
    end else begin
      if (fire) begin
        pend_q      <= 1'b1;
        pend_byte_q <= byte_i;
        pend_two_q  <= two_i;
        pend_brk_q  <= brk_i;
      end
      if (tick) begin
        unique case (state_q)
          ST_IDLE: begin
            if (have_next) begin
              txd_q     <= 1'b0;
              sh_q      <= next_byte;
              cur_two_q <= next_two;
              cur_brk_q <= next_brk;
              pend_q    <= 1'b0;
              state_q   <= ST_START;
            end
          end
          ST_START: begin
            txd_q   <= sh_q[0];
            sh_q    <= {1'b0, sh_q[DATA_BITS-1:1]};
            cnt_q   <= '0;
            state_q <= ST_DATA;
          end
          ST_DATA: begin
            if (cnt_q == DATA_LAST) begin
              txd_q   <= 1'b1;
              stop2_q <= 1'b0;
              state_q <= ST_STOP;
            end else begin
              txd_q <= sh_q[0];
              sh_q  <= {1'b0, sh_q[DATA_BITS-1:1]};
              cnt_q <= cnt_q + 1'b1;
            end
          end
          ST_STOP: begin
            if (!last_stop) begin
              stop2_q <= 1'b1;
            end else if (gap_next_i) begin
              txd_q   <= !cur_brk_q;
              cnt_q   <= '0;
              state_q <= ST_GAP;
            end else if (have_next) begin
              txd_q     <= 1'b0;
              sh_q      <= next_byte;
              cur_two_q <= next_two;
              cur_brk_q <= next_brk;
              pend_q    <= 1'b0;
              state_q   <= ST_START;
            end else begin
              state_q <= ST_IDLE;
            end
          end
          ST_GAP: begin
            if (cnt_q == GAP_LAST) begin
              txd_q   <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/uart_resync_tx.sv
module uart_resync_tx #(
  parameter int unsigned CLKS_PER_BIT = 434,
  parameter int unsigned DATA_BITS    = 8,
  parameter int unsigned GAP_EVERY    = 4,
  parameter int unsigned GAP_BITS     = 12
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [DATA_BITS-1:0] tx_data,
  input  logic                 tx_valid,
  output logic                 tx_ready,
  input  logic                 two_stop,
  input  logic                 break_mode,
  output logic                 txd,
  output logic                 busy
);
  logic bit_tick;
  logic char_end;
  logic gap_next;
  logic in_gap;

  uart_rtx_baud #(
    .CLKS_PER_BIT(CLKS_PER_BIT)
  ) u_baud (
    .clk  (clk),
    .rst  (rst),
    .tick (bit_tick)
  );

  uart_rtx_groupcnt #(
    .GAP_EVERY(GAP_EVERY)
  ) u_group (
    .clk      (clk),
    .rst      (rst),
    .char_end (char_end),
    .gap_next (gap_next)
  );

  uart_rtx_frame #(
    .DATA_BITS(DATA_BITS),
    .GAP_BITS (GAP_BITS)
  ) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick       (bit_tick),
    .byte_i     (tx_data),
    .valid_i    (tx_valid),
    .two_i      (two_stop),
    .brk_i      (break_mode),
    .gap_next_i (gap_next),
    .ready_o    (tx_ready),
    .busy_o     (busy),
    .txd_o      (txd),
    .char_end_o (char_end),
    .in_gap_o   (in_gap)
  );

endmodule

// File: rtl/uart_resync_tx_chk.sv
module uart_resync_tx_chk (
  input logic clk,
  input logic rst,
  input logic tx_valid,
  input logic tx_ready,
  input logic txd,
  input logic busy,
  input logic bit_tick,
  input logic in_gap
);

  a_r7_ready_drops: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> (!tx_ready && busy));

  a_r7_gap_blocks: assert property (@(posedge clk) disable iff (rst)
    in_gap |-> (!tx_ready && busy));

  a_r1_quiet_line: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (txd && tx_ready));

  a_r9_edge_on_tick: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable(txd));

  a_r2_start_busy: assert property (@(posedge clk) disable iff (rst)
    $fell(txd) |-> busy);

endmodule

bind uart_resync_tx uart_resync_tx_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .txd      (txd),
  .busy     (busy),
  .bit_tick (bit_tick),
  .in_gap   (in_gap)
);

// File: tb/uart_resync_tx_bench.sv
module uart_resync_tx_bench;
  localparam int CLK_PERIOD = 10;
  localparam int CPB        = 8;
  localparam int GAP_EVERY  = 3;
  localparam int GAP_BITS   = 12;

  typedef struct {
    logic [7:0] b;
    bit two;
    bit brk;
    bit gap;
    bit tight;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       two_stop = 1'b0;
  logic       break_mode = 1'b0;
  logic       tx_ready, txd, busy;

  int checks = 0;
  int errors = 0;
  int sent   = 0;
  longint cyc = 0;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  uart_resync_tx #(
    .CLKS_PER_BIT(CPB),
    .DATA_BITS   (8),
    .GAP_EVERY   (GAP_EVERY),
    .GAP_BITS    (GAP_BITS)
  ) u_uart_resync_tx (
    .clk        (clk),
    .rst        (rst),
    .tx_data    (tx_data),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .two_stop   (two_stop),
    .break_mode (break_mode),
    .txd        (txd),
    .busy       (busy)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic int frame_bits(input bit two);
    return two ? 11 : 10;
  endfunction

  task automatic send(input logic [7:0] b, input bit two, input bit brk, input bit tight);
    exp_t e;
    @(negedge clk);
    tx_data = b; two_stop = two; break_mode = brk; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(posedge clk);
    sent++;
    e.b = b; e.two = two; e.brk = brk; e.tight = tight;
    e.gap = ((sent % GAP_EVERY) == 0);
    q.push_back(e);
    #1 tx_valid = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (q.size() != 0 || busy) @(negedge clk);
    repeat (2*CPB) @(negedge clk);
  endtask

  task automatic reset_check();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk); rst = 1'b0;
    sent = 0;
    @(negedge clk);
    chk(txd == 1'b1, "R1 idle line", txd, 1);
    chk(tx_ready == 1'b1, "R1 ready", tx_ready, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
  endtask

  // Line decoder and timing monitor
  longint last_t = 0;
  bit have_last = 0;
  bit last_gap = 0;
  int last_frame = 10;

  task automatic decode();
    exp_t e;
    longint t0, d, mn;
    logic [7:0] got;
    t0 = cyc;
    if (q.size() == 0) begin
      chk(1'b0, "R2 unexpected start bit", 1, 0);
      return;
    end
    e = q.pop_front();
    if (have_last) begin
      d  = t0 - last_t;
      mn = longint'(last_frame*CPB) + (last_gap ? longint'((GAP_BITS+1)*CPB) : 0);
      if (e.tight && !last_gap) chk(d == mn, "R3 back-to-back spacing", d, mn);
      else if (last_gap)       chk(d >= mn, "R4 spacing after group gap", d, mn);
      else                     chk(d >= mn, "R6 minimum frame spacing", d, mn);
    end
    repeat (CPB/2) @(negedge clk);
    chk(txd == 1'b0, "R2 start bit", txd, 0);
    chk(!tx_ready && busy, "R7 ready low in frame", {tx_ready, busy}, 1);
    for (int j = 0; j < 8; j++) begin
      repeat (CPB) @(negedge clk);
      got[j] = txd;
    end
    if (!e.b[7]) begin
      repeat (CPB/2 - 1) @(negedge clk);
      chk(txd == 1'b0, "R3 last data cycle", txd, 0);
      @(negedge clk);
      chk(txd == 1'b1, "R3 stop edge at 9 bits", txd, 1);
      repeat (CPB/2) @(negedge clk);
    end else begin
      repeat (CPB) @(negedge clk);
    end
    chk(txd == 1'b1, "R2 stop bit", txd, 1);
    chk(got == e.b, "R2 data byte", got, e.b);
    if (e.two) begin
      repeat (CPB) @(negedge clk);
      chk(txd == 1'b1, "R6 second stop bit", txd, 1);
    end
    if (e.gap) begin
      for (int g = 0; g < GAP_BITS; g++) begin
        repeat (CPB) @(negedge clk);
        if (e.brk) chk(txd == 1'b0, "R5 break low", txd, 0);
        else       chk(txd == 1'b1, "R4 idle gap high", txd, 1);
        if (g == 0) chk(!tx_ready, "R7 ready low in gap", tx_ready, 0);
      end
      repeat (CPB) @(negedge clk);
      chk(txd == 1'b1, "R5 line high after gap", txd, 1);
    end
    last_t = t0; last_frame = frame_bits(e.two); last_gap = e.gap; have_last = 1;
  endtask

  initial begin
    logic prev;
    prev = 1'b1;
    forever begin
      @(negedge clk);
      if (!rst && prev && txd == 1'b0) decode();
      prev = txd;
    end
  end

  task automatic finish_up();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual busy=%0d expected run to end", busy);
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    reset_check();                                  // R1

    // R2 R3 R4: two idle-gap groups sent without pause
    send(8'h00, 0, 0, 0);
    send(8'hFF, 0, 0, 1);
    send(8'h55, 0, 0, 1);
    send(8'hA3, 0, 0, 1);
    send(8'h01, 0, 0, 1);
    send(8'h80, 0, 0, 1);
    wait_idle();

    // R5: break gap group
    send(8'h7E, 0, 1, 0);
    send(8'h9F, 0, 1, 1);
    send(8'h00, 0, 1, 1);
    wait_idle();

    // R6: two stop bits, tight
    send(8'h3C, 1, 0, 0);
    send(8'h00, 1, 1, 1);
    send(8'hC1, 1, 1, 1);
    send(8'h42, 1, 0, 1);
    wait_idle();
    send(8'h10, 0, 0, 0);
    send(8'h20, 0, 0, 1);
    wait_idle();

    // R8: reset part way through a group clears the count
    send(8'h11, 0, 0, 0);
    wait_idle();
    reset_check();
    send(8'h22, 0, 0, 0);
    send(8'h33, 0, 0, 1);
    send(8'h44, 0, 1, 1);
    wait_idle();

    // Random mix
    for (int i = 0; i < 36; i++) begin
      int dly;
      dly = ($urandom % 3 == 0) ? 0 : int'($urandom % 40);
      repeat (dly) @(negedge clk);
      send(8'($urandom), ($urandom % 4) == 0, ($urandom % 2) == 1, dly == 0);
    end
    wait_idle();
    chk(q.size() == 0, "R2 all bytes seen", q.size(), 0);
    chk(!busy && txd, "R1 quiet at end", {busy, txd}, 1);
    finish_up();
  end

endmodule